// File: doc/BRIEF.md
# Guarded-Write Control Register Bank

This block holds the control and status words of a communication controller. A host reaches it through a plain synchronous bus that has a word address, write data, a write strobe, a read strobe and registered read data. Fields come in three kinds. Plain read/write fields change only through the bus. Counter-like fields can also be loaded by controller hardware. Event flags are set by hardware and cleared by writing ones. Every writable field has a small set of permission terms, and a write goes through when at least one term is true. A write that meets none of its terms is dropped without any trace.

Some fields have reset sources beyond system reset. The first is a write of the start command code to the command field. The second is the end of a buffer shutdown handshake. In that handshake the host asks to disable an enabled message buffer, and the controller later grants the request. The grant clears the buffer's enable status and the fields tied to that buffer. The per-buffer cycle-filter, frame-identifier and index words are held in a RAM. They keep their contents through system reset, and they can only be changed while the buffer is disabled or the engine is in configuration mode.

Top module: `ccreg_bank`

## Requirements
- R1: After system reset, these all read zero: the command, configuration, flag and timer words, every buffer control word, and the `buf_en` and `dis_pend` outputs.
- R2: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled, and it shows the state from before any write made in that same cycle. Unmapped addresses read zero. These include 0x04–0x3F, buffer slots at or above NBUF, and 0x80 and up.
- R3: A write to the configuration word (address 0x01, bits 15:0) takes effect only when `eng_cfg_mode` or `eng_ready` is high. Otherwise the stored value does not change.
- R4: The flag word (address 0x02, bits NFLAG-1:0) reads its current state. A bus write clears each bit written as 1 and leaves each bit written as 0 unchanged. A high `hw_flag_set` bit sets the matching flag.
- R5: If a hardware set and a bus clear hit the same flag in one cycle, the flag ends up set.
- R6: The timer word (address 0x03, bits 15:0) is loaded from `hw_tmr_val` when `hw_tmr_ld` is high. A bus write changes it only when `eng_cfg_mode` is high. A hardware load wins over a bus write in the same cycle.
- R7: A write whose bits 3:0 equal 0101 to the command word (address 0x00) clears all flags and the timer, unless a hardware set or load acts in that cycle. Any other code only updates the readable command field. The configuration word is not affected.
- R8: Each buffer control word is at 0x40 + 4·n. Its bits are: [0] enabled status, [3] disable pending, [4] buffer flag (write-one-to-clear, set by `buf_evt[n]`) and [15:8] a control field. Writing bit 2 as 1 enables a disabled buffer. Writing bit 1 as 1 raises the disable request only if the buffer is enabled. Bits 1 and 2 read as zero.
- R9: A `dis_grant[n]` pulse while the request for buffer n is pending clears its enabled status, its pending bit, its flag and its control field at that clock edge. A grant with no pending request does nothing.
- R10: The memory words of buffer n are at 0x40 + 4·n + s, for s = 1 (cycle filter), 2 (frame ID) and 3 (index), each 16 bits wide. These words, and the control field [15:8], accept a write only when the buffer is disabled or `eng_cfg_mode` is high.
- R11: The memory words keep their contents through system reset.
- R12: Reserved bits always read zero, and writing them changes nothing. In the command word, only bits 3:0 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| eng_cfg_mode | input | 1 | Engine is in configuration mode (permission term) |
| eng_ready | input | 1 | Engine is in ready state (permission term) |
| hw_flag_set | input | NFLAG | Hardware flag set pulses |
| hw_tmr_ld | input | 1 | Hardware timer load strobe |
| hw_tmr_val | input | TMR_W | Hardware timer load value |
| buf_evt | input | NBUF | Per-buffer flag set pulses |
| dis_grant | input | NBUF | Controller grant pulses for buffer disable |
| dis_pend | output | NBUF | Disable request pending per buffer |
| buf_en | output | NBUF | Enabled status per buffer |

## Verification
The assertions expect reset to be high from time zero. They treat `dis_grant` as a pulse that may arrive whether or not a request is pending. The start-command property only applies in cycles with no hardware flag set and no timer load. The bench writes every memory word before it reads any of them, since the RAM has no reset value. Its random phase drives hardware sets, loads, events and grants sparsely and independently of the bus, so every priority collision occurs while every check keeps a defined expected value.

// File: rtl/ccreg_pkg.sv
`timescale 1ns/1ps
package ccreg_pkg;
  localparam int A_CMD    = 0;
  localparam int A_CFG    = 1;
  localparam int A_FLG    = 2;
  localparam int A_TMR    = 3;
  localparam int BUF_PAGE = 1;     // addr >> 6 == 1 selects the buffer page
  localparam int CMD_W    = 4;
  localparam int CTRL_W   = 8;
  localparam logic [CMD_W-1:0] CMD_START = 4'b0101;

  // word select inside a buffer slot
  typedef enum logic [1:0] {
    SEL_CSR = 2'd0,
    SEL_CYC = 2'd1,
    SEL_FID = 2'd2,
    SEL_IDX = 2'd3
  } slot_sel_e;

  // control word bit positions
  localparam int B_EN    = 0;
  localparam int B_DIS   = 1;
  localparam int B_ENA   = 2;
  localparam int B_PEND  = 3;
  localparam int B_FLAG  = 4;
  localparam int B_CTRL  = 8;
endpackage

// File: rtl/ccreg_w1c.sv
`timescale 1ns/1ps
module ccreg_w1c #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync_clr,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] base;
  logic [W-1:0] wipe;

  always_comb begin
    base = sync_clr ? '0 : q;
    wipe = clr_en ? clr_mask : '0;
  end

  // set is OR-ed last so a simultaneous event is never lost
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (base & ~wipe) | set_i;
  end
endmodule

// File: rtl/ccreg_bufctl.sv
`timescale 1ns/1ps
module ccreg_bufctl #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              wd_dis,
  input  logic              wd_ena,
  input  logic              wd_flag,
  input  logic [CTRL_W-1:0] wd_ctrl,
  input  logic              cfg_mode,
  input  logic              evt,
  input  logic              grant,
  output logic              en_q,
  output logic              pend_q,
  output logic              flag_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic grant_ok;
  logic ctrl_ok;

  assign grant_ok = grant & pend_q;
  assign ctrl_ok  = ~en_q | cfg_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else if (grant_ok) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else if (csr_wr) begin
      if (wd_dis && en_q)  pend_q <= 1'b1;
      if (wd_ena && !en_q) en_q   <= 1'b1;
      if (ctrl_ok)         ctrl_q <= wd_ctrl;
    end
  end

  ccreg_w1c #(.W(1)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .sync_clr (grant_ok),
    .set_i    (evt),
    .clr_en   (csr_wr),
    .clr_mask (wd_flag),
    .q        (flag_q)
  );
endmodule

// File: rtl/ccreg_ram.sv
`timescale 1ns/1ps
module ccreg_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // no reset: contents survive system reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ccreg_bank.sv
`timescale 1ns/1ps
module ccreg_bank
  import ccreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBUF   = 4,
  parameter int NFLAG  = 8,
  parameter int CFG_W  = 16,
  parameter int TMR_W  = 16,
  parameter int MEM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_cfg_mode,
  input  logic              eng_ready,
  input  logic [NFLAG-1:0]  hw_flag_set,
  input  logic              hw_tmr_ld,
  input  logic [TMR_W-1:0]  hw_tmr_val,
  input  logic [NBUF-1:0]   buf_evt,
  input  logic [NBUF-1:0]   dis_grant,
  output logic [NBUF-1:0]   dis_pend,
  output logic [NBUF-1:0]   buf_en
);
  localparam int BW     = $clog2(NBUF);
  localparam int DEPTH  = NBUF * 3;
  localparam int MIX_W  = $clog2(DEPTH);

  // ---------------- decode ----------------
  logic [3:0]       slot_id;
  logic [BW-1:0]    buf_ix;
  slot_sel_e        sel;
  logic             hit_cmd, hit_cfg, hit_flg, hit_tmr;
  logic             hit_buf, hit_csr, hit_mem;
  logic             run_cmd;
  int               mem_lin;
  logic [MIX_W-1:0] mem_ix;

  always_comb begin
    slot_id = bus_addr[5:2];
    buf_ix  = slot_id[BW-1:0];
    sel     = slot_sel_e'(bus_addr[1:0]);
    hit_cmd = (bus_addr == ADDR_W'(A_CMD));
    hit_cfg = (bus_addr == ADDR_W'(A_CFG));
    hit_flg = (bus_addr == ADDR_W'(A_FLG));
    hit_tmr = (bus_addr == ADDR_W'(A_TMR));
    hit_buf = ((bus_addr >> 6) == ADDR_W'(BUF_PAGE)) && (int'(slot_id) < NBUF);
    hit_csr = hit_buf && (sel == SEL_CSR);
    hit_mem = hit_buf && (sel != SEL_CSR);
    run_cmd = bus_wr && hit_cmd && (bus_wdata[CMD_W-1:0] == CMD_START);
    mem_lin = int'(slot_id) * 3 + int'(bus_addr[1:0]) - 1;
    mem_ix  = MIX_W'(mem_lin);
  end

  // ---------------- global fields ----------------
  logic [CMD_W-1:0] cmd_q;
  logic [CFG_W-1:0] cfg_q;
  logic [TMR_W-1:0] tmr_q;
  logic [NFLAG-1:0] flag_q;
  logic             cfg_ok;
  logic             tmr_ok;

  // OR of permission terms for each guarded field
  assign cfg_ok = eng_cfg_mode | eng_ready;
  assign tmr_ok = eng_cfg_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cfg_q <= '0;
      tmr_q <= '0;
    end else begin
      if (bus_wr && hit_cmd)           cmd_q <= bus_wdata[CMD_W-1:0];
      if (bus_wr && hit_cfg && cfg_ok) cfg_q <= bus_wdata[CFG_W-1:0];
      if (hw_tmr_ld)                   tmr_q <= hw_tmr_val;
      else if (run_cmd)                tmr_q <= '0;
      else if (bus_wr && hit_tmr && tmr_ok) tmr_q <= bus_wdata[TMR_W-1:0];
    end
  end

  ccreg_w1c #(.W(NFLAG)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .sync_clr (run_cmd),
    .set_i    (hw_flag_set),
    .clr_en   (bus_wr && hit_flg),
    .clr_mask (bus_wdata[NFLAG-1:0]),
    .q        (flag_q)
  );

  // ---------------- per-buffer control ----------------
  logic              en_v   [NBUF];
  logic              pend_v [NBUF];
  logic              bflg_v [NBUF];
  logic [CTRL_W-1:0] ctrl_v [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    ccreg_bufctl #(.CTRL_W(CTRL_W)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .csr_wr   (bus_wr && hit_csr && (int'(slot_id) == g)),
      .wd_dis   (bus_wdata[B_DIS]),
      .wd_ena   (bus_wdata[B_ENA]),
      .wd_flag  (bus_wdata[B_FLAG]),
      .wd_ctrl  (bus_wdata[B_CTRL +: CTRL_W]),
      .cfg_mode (eng_cfg_mode),
      .evt      (buf_evt[g]),
      .grant    (dis_grant[g]),
      .en_q     (en_v[g]),
      .pend_q   (pend_v[g]),
      .flag_q   (bflg_v[g]),
      .ctrl_q   (ctrl_v[g])
    );
    assign buf_en[g]   = en_v[g];
    assign dis_pend[g] = pend_v[g];
  end

  // ---------------- memory-backed words ----------------
  logic             mem_we;
  logic [MEM_W-1:0] ram_q;

  assign mem_we = bus_wr && hit_mem && (!en_v[buf_ix] || eng_cfg_mode);

  ccreg_ram #(.DW(MEM_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_ix),
    .wdata (bus_wdata[MEM_W-1:0]),
    .re    (bus_rd && hit_mem),
    .raddr (mem_ix),
    .rdata (ram_q)
  );

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_mem_q;

  always_comb begin
    rd_mux = '0;
    if (hit_cmd)      rd_mux[CMD_W-1:0] = cmd_q;
    else if (hit_cfg) rd_mux[CFG_W-1:0] = cfg_q;
    else if (hit_flg) rd_mux[NFLAG-1:0] = flag_q;
    else if (hit_tmr) rd_mux[TMR_W-1:0] = tmr_q;
    else if (hit_csr) begin
      rd_mux[B_EN]              = en_v[buf_ix];
      rd_mux[B_PEND]            = pend_v[buf_ix];
      rd_mux[B_FLAG]            = bflg_v[buf_ix];
      rd_mux[B_CTRL +: CTRL_W]  = ctrl_v[buf_ix];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rd_mem_q <= 1'b0;
    end else if (bus_rd) begin
      rdata_q  <= rd_mux;
      rd_mem_q <= hit_mem;
    end
  end

  assign bus_rdata = rd_mem_q ? {{(DATA_W-MEM_W){1'b0}}, ram_q} : rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:16];
endmodule

// File: rtl/ccreg_bank_chk.sv
`timescale 1ns/1ps
module ccreg_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBUF   = 4,
  parameter int NFLAG  = 8,
  parameter int CFG_W  = 16,
  parameter int TMR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_cfg_mode,
  input logic              eng_ready,
  input logic [NFLAG-1:0]  hw_flag_set,
  input logic              hw_tmr_ld,
  input logic [TMR_W-1:0]  hw_tmr_val,
  input logic [NBUF-1:0]   dis_grant,
  input logic [NBUF-1:0]   dis_pend,
  input logic [NBUF-1:0]   buf_en,
  input logic [NFLAG-1:0]  flag_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic [TMR_W-1:0]  tmr_q
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr >= ADDR_W'(4) && bus_addr < ADDR_W'(64)) |=> (bus_rdata == '0));

  assert_cfg_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == ADDR_W'(1) && (eng_cfg_mode || eng_ready)) |=> $stable(cfg_q));

  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(2) && hw_flag_set == '0)
      |=> (flag_q == ($past(flag_q) & ~$past(bus_wdata[NFLAG-1:0]))));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (hw_flag_set != '0) |=> ((flag_q & $past(hw_flag_set)) == $past(hw_flag_set)));

  assert_hw_load_R6: assert property (@(posedge clk) disable iff (rst)
    hw_tmr_ld |=> (tmr_q == $past(hw_tmr_val)));

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[3:0] == 4'b0101 &&
     !hw_tmr_ld && hw_flag_set == '0) |=> (flag_q == '0 && tmr_q == '0));

  assert_req_needs_en_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ((dis_pend & ~$past(dis_pend) & ~$past(buf_en)) == '0));

  assert_grant_clears_R9: assert property (@(posedge clk) disable iff (rst)
    ((dis_grant & dis_pend) != '0) |=> ((buf_en & $past(dis_grant & dis_pend)) == '0));
endmodule

bind ccreg_bank ccreg_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBUF(NBUF),
  .NFLAG(NFLAG), .CFG_W(CFG_W), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_cfg_mode(eng_cfg_mode),
  .eng_ready(eng_ready), .hw_flag_set(hw_flag_set), .hw_tmr_ld(hw_tmr_ld),
  .hw_tmr_val(hw_tmr_val), .dis_grant(dis_grant), .dis_pend(dis_pend),
  .buf_en(buf_en), .flag_q(flag_q), .cfg_q(cfg_q), .tmr_q(tmr_q)
);

// File: tb/ccreg_bank_tb.sv
`timescale 1ns/1ps
module ccreg_bank_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        eng_cfg_mode = 0, eng_ready = 0;
  logic [7:0]  hw_flag_set = 0;
  logic        hw_tmr_ld = 0;
  logic [15:0] hw_tmr_val = 0;
  logic [3:0]  buf_evt = 0, dis_grant = 0;
  logic [3:0]  dis_pend, buf_en;

  ccreg_bank u_dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic [3:0]  m_cmd;
  logic [15:0] m_cfg, m_tmr;
  logic [7:0]  m_flag;
  logic        m_en[4], m_pend[4], m_bf[4];
  logic [7:0]  m_ctrl[4];
  logic [15:0] m_mem[12];

  // next-cycle stimulus
  logic [7:0]  nx_a;
  logic [31:0] nx_d, rv;
  logic        nx_wr, nx_rd, nx_tl, pc, pr;
  logic [7:0]  nx_fs;
  logic [15:0] nx_tv;
  logic [3:0]  nx_ev, nx_gr;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int b;
    b = int'(a[5:2]);
    if (a == 0) return {28'h0, m_cmd};
    if (a == 1) return {16'h0, m_cfg};
    if (a == 2) return {24'h0, m_flag};
    if (a == 3) return {16'h0, m_tmr};
    if (a[7:6] == 2'b01 && b < 4) begin
      if (a[1:0] == 0) return {16'h0, m_ctrl[b], 3'b0, m_bf[b], m_pend[b], 2'b00, m_en[b]};
      return {16'h0, m_mem[b*3 + int'(a[1:0]) - 1]};
    end
    return 32'h0;
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_cfg = 0; m_tmr = 0; m_flag = 0;
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 0; m_pend[i] = 0; m_bf[i] = 0; m_ctrl[i] = 0;
    end
  endtask

  task automatic model_update();
    logic run, oen, isw, csrw, gok;
    run = bus_wr && bus_addr == 0 && bus_wdata[3:0] == 4'b0101;
    m_flag = ((run ? 8'h0 : m_flag) & ~((bus_wr && bus_addr == 2) ? bus_wdata[7:0] : 8'h0)) | hw_flag_set;
    if (hw_tmr_ld) m_tmr = hw_tmr_val;
    else if (run) m_tmr = 0;
    else if (bus_wr && bus_addr == 3 && eng_cfg_mode) m_tmr = bus_wdata[15:0];
    if (bus_wr && bus_addr == 1 && (eng_cfg_mode || eng_ready)) m_cfg = bus_wdata[15:0];
    if (bus_wr && bus_addr == 0) m_cmd = bus_wdata[3:0];
    for (int b = 0; b < 4; b++) begin
      oen  = m_en[b];
      isw  = bus_wr && bus_addr[7:6] == 2'b01 && int'(bus_addr[5:2]) == b;
      csrw = isw && bus_addr[1:0] == 0;
      gok  = dis_grant[b] && m_pend[b];
      if (isw && bus_addr[1:0] != 0 && (!oen || eng_cfg_mode))
        m_mem[b*3 + int'(bus_addr[1:0]) - 1] = bus_wdata[15:0];
      m_bf[b] = ((gok ? 1'b0 : m_bf[b]) & ~(csrw ? bus_wdata[4] : 1'b0)) | buf_evt[b];
      if (gok) begin
        m_en[b] = 0; m_pend[b] = 0; m_ctrl[b] = 0;
      end else if (csrw) begin
        if (bus_wdata[1] && oen) m_pend[b] = 1;
        if (bus_wdata[2] && !oen) m_en[b] = 1;
        if (!oen || eng_cfg_mode) m_ctrl[b] = bus_wdata[15:8];
      end
    end
  endtask

  task automatic clear_nx();
    nx_a = 0; nx_d = 0; nx_wr = 0; nx_rd = 0; nx_tl = 0;
    nx_fs = 0; nx_tv = 0; nx_ev = 0; nx_gr = 0;
  endtask

  task automatic step(input string tag);
    logic [31:0] e;
    logic        r;
    @(negedge clk);
    bus_addr = nx_a; bus_wdata = nx_d; bus_wr = nx_wr; bus_rd = nx_rd;
    hw_flag_set = nx_fs; hw_tmr_ld = nx_tl; hw_tmr_val = nx_tv;
    buf_evt = nx_ev; dis_grant = nx_gr; eng_cfg_mode = pc; eng_ready = pr;
    e = model_read(nx_a);
    r = nx_rd;
    @(posedge clk);
    model_update();
    #2;
    bus_wr = 0; bus_rd = 0; hw_flag_set = 0; hw_tmr_ld = 0; buf_evt = 0; dis_grant = 0;
    rv = bus_rdata;
    if (r) chk(tag, bus_rdata, e);
    clear_nx();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    nx_a = a; nx_d = d; nx_wr = 1;
    step("write");
  endtask

  task automatic rdc(input string tag, input logic [7:0] a, input logic [31:0] exp);
    nx_a = a; nx_rd = 1;
    step(tag);
    chk(tag, rv, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    model_reset();
  endtask

  function automatic string tag_of(input logic [7:0] a);
    if (a == 1) return "R3";
    if (a == 2) return "R4";
    if (a == 3) return "R6";
    if (a == 0) return "R12";
    if (a[7:6] == 2'b01 && a[5:2] < 4) return (a[1:0] == 0) ? "R8" : "R10";
    return "R2";
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    pc = 0; pr = 0;
    clear_nx();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rdc("R1", 8'h00, 0); rdc("R1", 8'h01, 0); rdc("R1", 8'h02, 0);
    rdc("R1", 8'h03, 0); rdc("R1", 8'h40, 0);
    chk("R1", {28'h0, buf_en}, 0); chk("R1", {28'h0, dis_pend}, 0);

    // R12 reserved bits
    wr(8'h00, 32'hFFFF_FFF3); rdc("R12", 8'h00, 32'h3);
    wr(8'h44, 32'hFFFF_00E0); rdc("R12", 8'h44, 32'h0);

    // R10 memory init under configuration mode
    pc = 1;
    for (int b = 0; b < 4; b++)
      for (int s = 1; s < 4; s++)
        wr(8'h40 + 8'(b*4 + s), 32'h1000 + 32'(b*16 + s));
    pc = 0;
    rdc("R10", 8'h45, 32'h1011);

    // R3 guarded configuration write
    wr(8'h01, 32'hBEEF); rdc("R3", 8'h01, 0);
    pr = 1; wr(8'h01, 32'hBEEF); rdc("R3", 8'h01, 32'hBEEF);
    pr = 0; pc = 1; wr(8'h01, 32'h1234); rdc("R3", 8'h01, 32'h1234); pc = 0;

    // R4 write-one-to-clear
    nx_fs = 8'hA5; step("R4"); rdc("R4", 8'h02, 32'hA5);
    wr(8'h02, 32'h05); rdc("R4", 8'h02, 32'hA0);
    wr(8'h02, 32'h00); rdc("R4", 8'h02, 32'hA0);

    // R5 set beats clear
    nx_fs = 8'h80; nx_a = 8'h02; nx_d = 32'h80; nx_wr = 1; step("R5");
    rdc("R5", 8'h02, 32'hA0);
    wr(8'h02, 32'hA0); rdc("R4", 8'h02, 0);

    // R6 timer
    nx_tl = 1; nx_tv = 16'h1234; step("R6"); rdc("R6", 8'h03, 32'h1234);
    wr(8'h03, 32'h5555); rdc("R6", 8'h03, 32'h1234);
    pc = 1; wr(8'h03, 32'h5555); rdc("R6", 8'h03, 32'h5555);
    nx_tl = 1; nx_tv = 16'h0ABC; nx_a = 8'h03; nx_d = 32'h7777; nx_wr = 1; step("R6");
    rdc("R6", 8'h03, 32'h0ABC); pc = 0;

    // R7 start command
    nx_fs = 8'h3C; step("R7");
    wr(8'h00, 32'h6); rdc("R7", 8'h02, 32'h3C); rdc("R7", 8'h03, 32'h0ABC);
    wr(8'h00, 32'h5); rdc("R7", 8'h02, 0); rdc("R7", 8'h03, 0);
    rdc("R7", 8'h00, 32'h5); rdc("R7", 8'h01, 32'h1234);

    // R8 enable and disable request
    wr(8'h44, 32'h2); chk("R8", {28'h0, dis_pend}, 0); rdc("R8", 8'h44, 0);
    wr(8'h44, 32'hAB04); rdc("R8", 8'h44, 32'hAB01);
    chk("R8", {28'h0, buf_en}, 32'h2);
    wr(8'h45, 32'h9999); rdc("R10", 8'h45, 32'h1011);
    pc = 1; wr(8'h45, 32'h2222); rdc("R10", 8'h45, 32'h2222); pc = 0;
    wr(8'h44, 32'hCD00); rdc("R10", 8'h44, 32'hAB01);
    nx_ev = 4'b0010; step("R8"); rdc("R8", 8'h44, 32'hAB11);
    wr(8'h44, 32'h2); chk("R8", {28'h0, dis_pend}, 32'h2);
    rdc("R8", 8'h44, 32'hAB19);

    // R9 grant handshake
    nx_gr = 4'b0100; step("R9");
    chk("R9", {28'h0, buf_en}, 32'h2); chk("R9", {28'h0, dis_pend}, 32'h2);
    rdc("R9", 8'h48, 0);
    nx_gr = 4'b0010; step("R9");
    chk("R9", {28'h0, buf_en}, 0); chk("R9", {28'h0, dis_pend}, 0);
    rdc("R9", 8'h44, 0); rdc("R9", 8'h45, 32'h2222);

    // R11 memory survives reset
    do_reset();
    rdc("R11", 8'h45, 32'h2222); rdc("R11", 8'h4B, 32'h1023);
    rdc("R1", 8'h01, 0);

    // R2 latency and unmapped space
    rdc("R2", 8'h10, 0); rdc("R2", 8'h60, 0); rdc("R2", 8'hC1, 0);
    pr = 1; nx_a = 8'h01; nx_d = 32'h4321; nx_wr = 1; nx_rd = 1; step("R2");
    chk("R2", rv, 0); rdc("R2", 8'h01, 32'h4321); pr = 0;

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      k = int'($urandom % 10);
      case (k)
        0: nx_a = 8'h00;
        1: nx_a = 8'h01;
        2: nx_a = 8'h02;
        3: nx_a = 8'h03;
        4, 5, 6, 7: nx_a = 8'h40 | 8'($urandom % 16);
        8: nx_a = 8'(4 + $urandom % 60);
        default: nx_a = 8'($urandom);
      endcase
      nx_d  = $urandom;
      if (k == 0 && ($urandom % 2) == 0) nx_d[3:0] = 4'b0101;
      nx_wr = ($urandom % 2) == 0;
      nx_rd = ($urandom % 2) == 0;
      nx_fs = 8'($urandom & $urandom & $urandom);
      nx_tl = ($urandom % 8) == 0;
      nx_tv = 16'($urandom);
      nx_ev = 4'($urandom & $urandom & $urandom);
      nx_gr = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      pc = ($urandom % 4) == 0;
      pr = ($urandom % 3) == 0;
      step(tag_of(nx_a));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule